// File: doc/BRIEF.md
# Oversampling Serial Receiver with Address-Frame Recognition

This block recovers asynchronous serial frames of 8 or 9 data bits from a single line. It runs from the system clock and advances only on a pre-divided tick enable. A two-bit ratio select sets how many ticks make up one bit period: 16, 8, 6 or 4. A loopback select makes the receiver listen to the local transmit line instead of the receive pin. The block has no transmitter, baud generator, FIFO or register bus.

In 9-bit operation a multiprocessor mode can be switched on. A frame whose ninth bit matches a configured address-bit value is then an address frame. It is always delivered and it raises an address interrupt pulse. A block input drops every frame that is not an address frame, so a listener can ignore traffic until it is addressed. Each delivered word appears with a one-cycle valid strobe. When stop-bit checking is active, a low stop bit raises a one-cycle frame-error pulse. A half-stop setting turns the check off.

The controller has four states. IDLE waits for a falling edge seen on a tick, which leads to START. START samples at the half-bit point: a high line means a glitch and the block goes back to IDLE, while a low line moves it to DATA. DATA takes one sample per bit period, least significant bit first, and moves to STOP after the last data bit. STOP samples the stop bit one bit period later, issues the result, and returns to IDLE.

Top module: `uart_os_rx`

## Requirements
- R1: `ovs_sel` sets the ticks per bit period: 0 gives 16, 1 gives 8, 2 gives 6 and 3 gives 4. Frames sent at the matching rate are received correctly at every setting.
- R2: A frame starts on a high-to-low change of the line seen on a tick. If the line is high again at the half-bit tick of the start bit, the receiver goes back to idle and reports nothing.
- R3: Data bits are received least significant bit first. With `nine_bit`=1 the frame carries 9 data bits and `rx_data[8]` is the ninth bit. With `nine_bit`=0 the frame carries 8 bits and `rx_data[8]` reads 0.
- R4: `rx_valid` is a one-cycle pulse, issued once for each delivered frame, and `rx_data` holds the word while it is high.
- R5: With `mp_en`=0 or `nine_bit`=0, the ninth bit is ordinary data and `addr_irq` stays low.
- R6: With `nine_bit`=1 and `mp_en`=1, a frame whose ninth bit equals `mp_addr_bit` is an address frame. It is delivered even while `rx_block`=1, and `addr_irq` pulses in the same cycle as `rx_valid`.
- R7: While `rx_block`=1, frames that are not address frames are dropped and raise no `rx_valid`.
- R8: With `loopback`=1 the receiver takes its input from `tx_line` and ignores `rx_pin`. With `loopback`=0 it takes `rx_pin` and ignores `tx_line`.
- R9: With `half_stop`=0, a stop bit sampled low gives a one-cycle `frame_err` pulse, and the word is still delivered subject to R6 and R7.
- R10: With `half_stop`=1, the stop bit is not checked and `frame_err` stays low.
- R11: During reset and right after it, all outputs are 0 and the receiver is idle. A reset in the middle of a frame leaves the receiver ready for the next frame.
- R12: All bit timing counts only the cycles in which `tick_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Pre-divided oversampling tick |
| ovs_sel | input | 2 | Ticks-per-bit select (0:16, 1:8, 2:6, 3:4) |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| mp_en | input | 1 | Multiprocessor address mode enable |
| mp_addr_bit | input | 1 | Ninth-bit value that marks an address frame |
| rx_block | input | 1 | Drop frames that are not address frames |
| loopback | input | 1 | Take receiver input from tx_line |
| half_stop | input | 1 | Half-stop setting; disables the stop-bit check |
| rx_pin | input | 1 | Serial receive line, idle high |
| tx_line | input | 1 | Local transmit line used in loopback |
| rx_data | output | 9 | Received word |
| rx_valid | output | 1 | One-cycle strobe for a delivered word |
| frame_err | output | 1 | One-cycle stop-bit error pulse |
| addr_irq | output | 1 | One-cycle address-frame pulse |

## Verification
The assertions assume that every configuration input (`ovs_sel`, `nine_bit`, `mp_en`, `mp_addr_bit`, `rx_block`, `half_stop`, `loopback`) stays still while a frame is in flight. A change in mid-frame could push the tick counter past the limit of the new ratio, or could classify a frame against settings that no longer apply. The bench changes settings only after a gap of at least three idle bit periods. It drives each bit for exactly the chosen number of ticks, so every sample falls well inside its bit and the sampled value is unambiguous.

// File: rtl/uart_osrx_pkg.sv
package uart_osrx_pkg;

    localparam int unsigned MAX_TPB = 16;
    localparam int unsigned CNT_W   = $clog2(MAX_TPB);
    localparam int unsigned WORD_W  = 9;
    localparam int unsigned IDX_W   = $clog2(WORD_W + 1);

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    // last tick index of a bit period for each ratio select
    function automatic logic [CNT_W-1:0] tpb_last(input logic [1:0] sel);
        logic [CNT_W-1:0] r;
        unique case (sel)
            2'd0: r = CNT_W'(15);
            2'd1: r = CNT_W'(7);
            2'd2: r = CNT_W'(5);
            default: r = CNT_W'(3);
        endcase
        return r;
    endfunction

    // tick index at which the start bit is confirmed (half a period in)
    function automatic logic [CNT_W-1:0] tpb_half(input logic [1:0] sel);
        logic [CNT_W-1:0] r;
        unique case (sel)
            2'd0: r = CNT_W'(7);
            2'd1: r = CNT_W'(3);
            2'd2: r = CNT_W'(2);
            default: r = CNT_W'(1);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/osrx_line_sel.sv
module osrx_line_sel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic loopback,
    input  logic rx_pin,
    input  logic tx_line,
    output logic line
);
    logic                   raw;
    logic [SYNC_STAGES-1:0] sync_q;

    assign raw  = loopback ? tx_line : rx_pin;
    assign line = sync_q[SYNC_STAGES-1];

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b1;
                    else        sync_q[0] <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b1;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // the synchroniser output follows the selected source after SYNC_STAGES clocks
    p_loop_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (loopback && $past(loopback) && $past(loopback, 2) && $past(rst_n, 2)
         && $stable(tx_line) && $past(tx_line) == $past(tx_line, 2))
        |-> (line == tx_line || SYNC_STAGES > 2));

endmodule

// File: rtl/osrx_bit_timer.sv
module osrx_bit_timer
    import uart_osrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       restart,
    input  logic [1:0] ovs_sel,
    output logic       half_pt,
    output logic       full_pt
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_idx;
    logic [CNT_W-1:0] half_idx;

    always_comb begin
        last_idx = tpb_last(ovs_sel);
        half_idx = tpb_half(ovs_sel);
        half_pt  = tick && (cnt == half_idx);
        full_pt  = tick && (cnt == last_idx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (restart)  cnt <= '0;
        else if (full_pt)  cnt <= '0;
        else if (tick)     cnt <= cnt + 1'b1;
    end

    // counter never runs past the period selected by the ratio input
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last_idx);

    // counting only moves on enabled ticks
    p_tick_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick) && !$past(restart) && $past(rst_n)) |-> $stable(cnt));

endmodule

// File: rtl/osrx_frame_fsm.sv
module osrx_frame_fsm
    import uart_osrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  logic              nine_bit,
    input  logic              half_pt,
    input  logic              full_pt,
    output logic              restart,
    output logic              frame_done,
    output logic              stop_bit,
    output logic [WORD_W-1:0] shreg
);
    rx_state_e        state, state_nx;
    logic             prev_line;
    logic [IDX_W-1:0] bit_idx;
    logic [IDX_W-1:0] bit_last;

    assign bit_last = nine_bit ? IDX_W'(WORD_W - 1) : IDX_W'(WORD_W - 2);

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:  if (tick && prev_line && !line) state_nx = RX_START;
            RX_START: if (half_pt) state_nx = line ? RX_IDLE : RX_DATA;
            RX_DATA:  if (full_pt && bit_idx == bit_last) state_nx = RX_STOP;
            RX_STOP:  if (full_pt) state_nx = RX_IDLE;
            default:  state_nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        restart    = (state == RX_IDLE) || (state == RX_START && half_pt);
        frame_done = (state == RX_STOP) && full_pt;
        stop_bit   = line;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_line <= 1'b1;
            bit_idx   <= '0;
            shreg     <= '0;
        end else begin
            if (tick) prev_line <= line;
            if (state == RX_START) begin
                bit_idx <= '0;
            end else if (state == RX_DATA && full_pt) begin
                bit_idx <= bit_idx + 1'b1;
                shreg   <= {line, shreg[WORD_W-1:1]};
            end
        end
    end

    // leaving idle needs a high-to-low change seen on a tick
    p_idle_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_START && $past(state) == RX_IDLE)
        |-> ($past(prev_line) && !$past(line) && $past(tick)));

    // the data phase is entered only from a start bit confirmed low
    p_start_confirm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_DATA && $past(state) == RX_START) |-> !$past(line));

    // bit index never passes the last data bit
    p_bit_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state == RX_DATA |-> bit_idx <= bit_last);

endmodule

// File: rtl/osrx_frame_classify.sv
module osrx_frame_classify
    import uart_osrx_pkg::*;
(
    input  logic [WORD_W-1:0] shreg,
    input  logic              nine_bit,
    input  logic              mp_en,
    input  logic              mp_addr_bit,
    input  logic              rx_block,
    output logic [WORD_W-1:0] word,
    output logic              is_addr,
    output logic              deliver
);
    always_comb begin
        word    = nine_bit ? shreg : {1'b0, shreg[WORD_W-1:1]};
        is_addr = nine_bit && mp_en && (shreg[WORD_W-1] == mp_addr_bit);
        deliver = is_addr || !rx_block;
    end
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import uart_osrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [1:0]        ovs_sel,
    input  logic              nine_bit,
    input  logic              mp_en,
    input  logic              mp_addr_bit,
    input  logic              rx_block,
    input  logic              loopback,
    input  logic              half_stop,
    input  logic              rx_pin,
    input  logic              tx_line,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              frame_err,
    output logic              addr_irq
);
    logic              line;
    logic              restart;
    logic              half_pt;
    logic              full_pt;
    logic              frame_done;
    logic              stop_bit;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] word;
    logic              is_addr;
    logic              deliver;

    osrx_line_sel #(.SYNC_STAGES(2)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .loopback (loopback),
        .rx_pin   (rx_pin),
        .tx_line  (tx_line),
        .line     (line)
    );

    osrx_bit_timer u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_en),
        .restart  (restart),
        .ovs_sel  (ovs_sel),
        .half_pt  (half_pt),
        .full_pt  (full_pt)
    );

    osrx_frame_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_en),
        .line       (line),
        .nine_bit   (nine_bit),
        .half_pt    (half_pt),
        .full_pt    (full_pt),
        .restart    (restart),
        .frame_done (frame_done),
        .stop_bit   (stop_bit),
        .shreg      (shreg)
    );

    osrx_frame_classify u_class (
        .shreg       (shreg),
        .nine_bit    (nine_bit),
        .mp_en       (mp_en),
        .mp_addr_bit (mp_addr_bit),
        .rx_block    (rx_block),
        .word        (word),
        .is_addr     (is_addr),
        .deliver     (deliver)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data   <= '0;
            rx_valid  <= 1'b0;
            frame_err <= 1'b0;
            addr_irq  <= 1'b0;
        end else begin
            rx_valid  <= 1'b0;
            frame_err <= 1'b0;
            addr_irq  <= 1'b0;
            if (frame_done) begin
                rx_valid  <= deliver;
                addr_irq  <= is_addr;
                frame_err <= !half_stop && !stop_bit;
                if (deliver) rx_data <= word;
            end
        end
    end

    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_ferr_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    p_irq_delivered_r6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_irq |-> rx_valid);

    p_irq_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_irq |-> ($past(mp_en) && $past(nine_bit) && rx_data[WORD_W-1] == $past(mp_addr_bit)));

    p_block_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !addr_irq) |-> !$past(rx_block));

    p_half_no_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> !$past(half_stop));

    p_word8_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !$past(nine_bit)) |-> !rx_data[WORD_W-1]);

    always_comb begin
        if (!rst_n) begin
            p_reset_quiet_r11: assert (!rx_valid && !frame_err && !addr_irq);
        end
    end

endmodule

// File: tb/uart_os_rx_tb.sv
module uart_os_rx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [1:0] ovs_sel = 2'd0;
    logic       nine_bit = 1'b0;
    logic       mp_en = 1'b0;
    logic       mp_addr_bit = 1'b0;
    logic       rx_block = 1'b0;
    logic       loopback = 1'b0;
    logic       half_stop = 1'b0;
    logic       rx_pin = 1'b1;
    logic       tx_line = 1'b1;
    logic [8:0] rx_data;
    logic       rx_valid;
    logic       frame_err;
    logic       addr_irq;

    always #5 clk = ~clk;

    uart_os_rx u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ovs_sel(ovs_sel),
        .nine_bit(nine_bit), .mp_en(mp_en), .mp_addr_bit(mp_addr_bit),
        .rx_block(rx_block), .loopback(loopback), .half_stop(half_stop),
        .rx_pin(rx_pin), .tx_line(tx_line), .rx_data(rx_data),
        .rx_valid(rx_valid), .frame_err(frame_err), .addr_irq(addr_irq)
    );

    int div = 1;
    int tick_cnt = 0;
    always @(negedge clk) begin
        if (tick_cnt >= div - 1) begin
            tick_en = 1'b1;
            tick_cnt = 0;
        end else begin
            tick_en = 1'b0;
            tick_cnt++;
        end
    end

    int n_val = 0, n_ferr = 0, n_irq = 0;
    logic [8:0] last_data = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                n_val++;
                last_data = rx_data;
            end
            if (frame_err) n_ferr++;
            if (addr_irq)  n_irq++;
        end
    end

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int tpb(input logic [1:0] s);
        case (s)
            2'd0: return 16;
            2'd1: return 8;
            2'd2: return 6;
            default: return 4;
        endcase
    endfunction

    task automatic drive_line(input logic use_tx, input logic v);
        if (use_tx) tx_line = v;
        else        rx_pin  = v;
    endtask

    task automatic send_frame(input logic [8:0] d, input int nbits, input logic stop_lvl,
                              input logic use_tx, input int bc, input int gap);
        drive_line(use_tx, 1'b0);
        repeat (bc) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            drive_line(use_tx, d[i]);
            repeat (bc) @(negedge clk);
        end
        drive_line(use_tx, stop_lvl);
        repeat (bc) @(negedge clk);
        drive_line(use_tx, 1'b1);
        repeat (gap * bc) @(negedge clk);
    endtask

    typedef struct packed {
        logic [1:0] ovs;
        logic       nine;
        logic       mp;
        logic       mpab;
        logic       blk;
        logic       half;
        logic       loop;
        logic       on_tx;
        logic       stop;
        logic [8:0] data;
        logic       e_val;
        logic [8:0] e_data;
        logic       e_ferr;
        logic       e_irq;
    } vec_t;

    localparam int NV = 15;
    // ovs nine mp mpab blk half loop on_tx stop data   e_val e_data e_ferr e_irq
    localparam vec_t VECS [NV] = '{
        '{2'd0, 0, 0, 0, 0, 0, 0, 0, 1, 9'h0A5, 1, 9'h0A5, 0, 0}, // R1 R3 x16
        '{2'd1, 0, 0, 0, 0, 0, 0, 0, 1, 9'h03C, 1, 9'h03C, 0, 0}, // R1 x8
        '{2'd2, 0, 0, 0, 0, 0, 0, 0, 1, 9'h0F1, 1, 9'h0F1, 0, 0}, // R1 x6
        '{2'd3, 0, 0, 0, 0, 0, 0, 0, 1, 9'h16E, 1, 9'h06E, 0, 0}, // R1 R3 x4, bit8 reads 0
        '{2'd0, 1, 0, 0, 0, 0, 0, 0, 1, 9'h1C3, 1, 9'h1C3, 0, 0}, // R5 ninth bit is data
        '{2'd1, 1, 1, 1, 1, 0, 0, 0, 1, 9'h155, 1, 9'h155, 0, 1}, // R6 address while blocked
        '{2'd1, 1, 1, 1, 1, 0, 0, 0, 1, 9'h055, 0, 9'h000, 0, 0}, // R7 data frame dropped
        '{2'd1, 1, 1, 0, 0, 0, 0, 0, 1, 9'h0AA, 1, 9'h0AA, 0, 1}, // R6 address bit value 0
        '{2'd2, 1, 1, 0, 0, 0, 0, 0, 1, 9'h1AA, 1, 9'h1AA, 0, 0}, // R6 non-matching ninth bit
        '{2'd0, 0, 0, 0, 1, 0, 0, 0, 1, 9'h077, 0, 9'h000, 0, 0}, // R7 block without mp
        '{2'd3, 0, 0, 0, 0, 0, 1, 1, 1, 9'h05A, 1, 9'h05A, 0, 0}, // R8 loopback from tx_line
        '{2'd3, 0, 0, 0, 0, 0, 0, 1, 1, 9'h05A, 0, 9'h000, 0, 0}, // R8 tx_line ignored
        '{2'd3, 0, 0, 0, 0, 0, 1, 0, 1, 9'h05A, 0, 9'h000, 0, 0}, // R8 rx_pin ignored in loopback
        '{2'd2, 0, 0, 0, 0, 0, 0, 0, 0, 9'h033, 1, 9'h033, 1, 0}, // R9 low stop bit
        '{2'd2, 0, 0, 0, 0, 1, 0, 0, 0, 9'h033, 1, 9'h033, 0, 0}  // R10 half-stop no check
    };

    initial begin
        int bv, bf, bi;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", "rx_valid in reset", int'(rx_valid), 0);
        check("R11", "frame_err in reset", int'(frame_err), 0);
        check("R11", "addr_irq in reset", int'(addr_irq), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R11", "rx_data after reset", int'(rx_data), 0);
        check("R11", "no pulse after reset", n_val + n_ferr + n_irq, 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            ovs_sel = VECS[v].ovs; nine_bit = VECS[v].nine; mp_en = VECS[v].mp;
            mp_addr_bit = VECS[v].mpab; rx_block = VECS[v].blk; half_stop = VECS[v].half;
            loopback = VECS[v].loop;
            repeat (4) @(negedge clk);
            bv = n_val; bf = n_ferr; bi = n_irq;
            send_frame(VECS[v].data, VECS[v].nine ? 9 : 8, VECS[v].stop, VECS[v].on_tx,
                       tpb(VECS[v].ovs), 3);
            check("R4", $sformatf("vec %0d valid count", v), n_val - bv, int'(VECS[v].e_val));
            if (VECS[v].e_val)
                check("R3", $sformatf("vec %0d word", v), int'(last_data), int'(VECS[v].e_data));
            check("R9", $sformatf("vec %0d frame_err count", v), n_ferr - bf, int'(VECS[v].e_ferr));
            check("R6", $sformatf("vec %0d addr_irq count", v), n_irq - bi, int'(VECS[v].e_irq));
        end
        ovs_sel = 2'd0; nine_bit = 0; mp_en = 0; mp_addr_bit = 0; rx_block = 0;
        half_stop = 0; loopback = 0;
        repeat (4) @(negedge clk);

        // R2 glitch shorter than half a bit, then a good frame
        bv = n_val;
        rx_pin = 1'b0;
        repeat (3) @(negedge clk);
        rx_pin = 1'b1;
        repeat (40) @(negedge clk);
        check("R2", "glitch raises no valid", n_val - bv, 0);
        send_frame(9'h0C9, 8, 1'b1, 1'b0, 16, 3);
        check("R2", "frame after glitch count", n_val - bv, 1);
        check("R2", "frame after glitch word", int'(last_data), 9'h0C9);

        // R4 back-to-back frames with no idle gap
        bv = n_val;
        ovs_sel = 2'd1;
        repeat (4) @(negedge clk);
        send_frame(9'h012, 8, 1'b1, 1'b0, 8, 0);
        send_frame(9'h0ED, 8, 1'b1, 1'b0, 8, 3);
        check("R4", "back-to-back count", n_val - bv, 2);
        check("R4", "back-to-back second word", int'(last_data), 9'h0ED);

        // R12 ticks every third clock, ratio 8
        div = 3;
        repeat (6) @(negedge clk);
        bv = n_val;
        send_frame(9'h096, 8, 1'b1, 1'b0, 24, 3);
        check("R12", "gated tick frame count", n_val - bv, 1);
        check("R12", "gated tick word", int'(last_data), 9'h096);
        div = 1;
        repeat (6) @(negedge clk);

        // R11 reset in the middle of a frame
        ovs_sel = 2'd0;
        repeat (4) @(negedge clk);
        bv = n_val;
        rx_pin = 1'b0;
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rx_pin = 1'b1;
        check("R11", "outputs low in mid-frame reset", int'({rx_valid, frame_err, addr_irq}), 0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        send_frame(9'h03F, 8, 1'b1, 1'b0, 16, 3);
        check("R11", "frame after mid-frame reset count", n_val - bv, 1);
        check("R11", "frame after mid-frame reset word", int'(last_data), 9'h03F);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule